// File: doc/BRIEF.md
# Bang-Bang Clock-Recovery Phase Tracker

This block steers the sampling phase of a serial receiver. The analog front end has already sliced the line into one data sample and one edge sample per bit period. Each bit arrives on a valid strobe. The block compares the previous data sample, the new data sample and the edge sample taken between them. From these it decides whether the sampling clock sits early or late. It reports only the sign of the error, and only when the two data samples differ.

A digital loop filter converts the decisions into motion of a phase-select code. The filter has a proportional path and an integral path. The integral accumulator saturates. A fractional residue carries the sub-step remainder from one decision to the next. The code selects one of five equally spaced coarse clock phases plus a fine interpolation step. It wraps around in both directions, so the recovered clock can rotate without limit and follow a frequency offset.

Top module: `bbcdr_tracker`

## Requirements
- R1: While `rst` is high on a clock edge, the phase code returns to coarse 0 / fine 0, the integral accumulator and the fractional residue clear, and both decision pulses are low.
- R2: For an accepted bit whose data sample differs from the previous one, "late" is decided when the edge sample differs from the previous data sample.
- R3: For an accepted bit whose data sample differs from the previous one, "early" is decided when the edge sample differs from the new data sample.
- R4: A bit whose data sample equals the previous one, and any cycle with `smp_valid` low, yields no pulse and leaves the code, accumulator and residue unchanged, whatever `edge_smp` and `data_smp` carry.
- R5: The first accepted bit after reset only loads the previous-data register; it produces no decision.
- R6: `early_pulse` and `late_pulse` are registered, one clock wide, appear on the clock after the deciding strobe, and are never high together.
- R7: Each decision has sign s (+1 early, −1 late) and moves the code at the clock after the strobe. The integral accumulator first takes s·2^KI_SHIFT. The loop then forms total = s·2^KP_SHIFT + accumulator + residue, in units of 2^−FRAC_BITS code steps. The code advances by floor(total / 2^FRAC_BITS), and the remainder becomes the new residue.
- R8: The integral accumulator saturates at −2^(ACC_W−1) and 2^(ACC_W−1)−1 instead of wrapping. With the defaults, a saturated early run moves the code by exactly 527 steps every 16 decisions.
- R9: The code runs over 80 positions (5 coarse × 16 fine). Advancing past coarse 4 / fine 15 wraps to 0/0, and stepping below 0/0 wraps to 4/15. The coarse index never exceeds 4.
- R10: The code position is coarse·16 + fine. `phase_coarse` is a 3-bit index and `phase_fine` is a 4-bit step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new bit (data and edge sample) is presented |
| data_smp | input | 1 | Data sample of the current bit, D(n+1) |
| edge_smp | input | 1 | Edge sample between previous and current bit, E(n) |
| early_pulse | output | 1 | Registered one-clock "clock early" decision |
| late_pulse | output | 1 | Registered one-clock "clock late" decision |
| phase_coarse | output | 3 | Coarse clock phase index, 0 to 4 |
| phase_fine | output | 4 | Fine interpolation step within the coarse phase |

## Verification
The assertions assume that `rst` is high from time zero until the first edges. They also assume that the loop gains keep a single move smaller than the 80-position code ring. The defaults allow at most about 33 steps per move. The bench holds reset across the first edges and runs with the default gains. It drives samples half a period away from the sampling edge, so every strobe is seen exactly once. The stimulus includes long one-sided runs that pin the accumulator against both limits and carry the code around the ring.

// File: rtl/bbcdr_pkg.sv
package bbcdr_pkg;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_EARLY = 2'd1,
    DIR_LATE  = 2'd2
  } pd_dir_t;

  // signed add clamped to a w-bit two's-complement range
  function automatic int sat_add(input int a, input int d, input int w);
    int hi;
    int lo;
    int s;
    hi = (1 <<< (w - 1)) - 1;
    lo = -(1 <<< (w - 1));
    s  = a + d;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return s;
  endfunction

  // position on a ring of span entries after a signed move
  function automatic int ring_add(input int pos, input int mv, input int span);
    int t;
    t = pos + mv;
    if (t < 0) t = t + span;
    else if (t >= span) t = t - span;
    return t;
  endfunction

endpackage

// File: rtl/bbcdr_pd.sv
module bbcdr_pd
  import bbcdr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    smp_valid,
  input  logic    data_smp,
  input  logic    edge_smp,
  output pd_dir_t dir,
  output logic    early_q,
  output logic    late_q
);

  logic prev_q;
  logic have_q;
  logic trans;
  logic says_late;
  logic says_early;

  assign trans      = smp_valid & have_q & (prev_q ^ data_smp);
  assign says_late  = trans & (prev_q ^ edge_smp);
  assign says_early = trans & (edge_smp ^ data_smp);

  always_comb begin
    if (says_early)     dir = DIR_EARLY;
    else if (says_late) dir = DIR_LATE;
    else                dir = DIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      early_q <= says_early;
      late_q  <= says_late;
      if (smp_valid) begin
        prev_q <= data_smp;
        have_q <= 1'b1;
      end
    end
  end

  assert_first_bit_R5: assert property (@(posedge clk) disable iff (rst)
    !have_q |=> !early_q && !late_q);

  assert_one_sided_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({early_q, late_q}));

endmodule

// File: rtl/bbcdr_loopfilt.sv
module bbcdr_loopfilt
  import bbcdr_pkg::*;
#(
  parameter int KP_SHIFT  = 4,
  parameter int KI_SHIFT  = 0,
  parameter int FRAC_BITS = 4,
  parameter int ACC_W     = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  pd_dir_t dir,
  output int      move
);

  localparam int ACC_HI = (1 <<< (ACC_W - 1)) - 1;
  localparam int ACC_LO = -(1 <<< (ACC_W - 1));
  localparam int KI_W   = 1 <<< KI_SHIFT;

  logic signed [ACC_W-1:0]     acc_q;
  logic        [FRAC_BITS-1:0] resid_q;
  logic                        dec;
  int                          sgn;
  int                          acc_nx;
  int                          total;
  int                          mv;
  int                          resid_nx;

  assign dec = (dir != DIR_NONE);

  always_comb begin
    case (dir)
      DIR_EARLY: sgn = 1;
      DIR_LATE:  sgn = -1;
      default:   sgn = 0;
    endcase
    acc_nx   = sat_add(int'(acc_q), sgn * KI_W, ACC_W);
    total    = sgn * (1 <<< KP_SHIFT) + acc_nx + int'({1'b0, resid_q});
    mv       = total >>> FRAC_BITS;
    resid_nx = total - (mv <<< FRAC_BITS);
  end

  assign move = dec ? mv : 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      resid_q <= '0;
    end else if (dec) begin
      acc_q   <= ACC_W'(acc_nx);
      resid_q <= FRAC_BITS'(resid_nx);
    end
  end

  assert_acc_step_R7: assert property (@(posedge clk) disable iff (rst)
    ((int'(acc_q) - int'($past(acc_q))) <= KI_W) &&
    ((int'(acc_q) - int'($past(acc_q))) >= -KI_W));

  assert_acc_sat_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(acc_q) == ACC_HI && dir == DIR_EARLY) |=> int'(acc_q) == ACC_HI);

  assert_acc_sat_lo_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(acc_q) == ACC_LO && dir == DIR_LATE) |=> int'(acc_q) == ACC_LO);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !dec |=> $stable(acc_q) && $stable(resid_q));

endmodule

// File: rtl/bbcdr_rotator.sv
module bbcdr_rotator #(
  parameter int COARSE_N = 5,
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_en,
  input  int                  move,
  output logic [COARSE_W-1:0] coarse,
  output logic [FINE_W-1:0]   fine
);

  import bbcdr_pkg::*;

  localparam int SPAN  = COARSE_N << FINE_W;
  localparam int LIN_W = $clog2(SPAN);

  logic [LIN_W-1:0] lin_q;
  int               lin_nx;

  assign lin_nx = ring_add(int'(lin_q), move, SPAN);
  assign coarse = COARSE_W'(lin_q >> FINE_W);
  assign fine   = lin_q[FINE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)          lin_q <= '0;
    else if (step_en) lin_q <= LIN_W'(lin_nx);
  end

  assert_coarse_range_R9: assert property (@(posedge clk) disable iff (rst)
    int'(coarse) < COARSE_N);

  assert_move_in_ring_R9: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (move < SPAN) && (move > -SPAN));

endmodule

// File: rtl/bbcdr_tracker.sv
module bbcdr_tracker
  import bbcdr_pkg::*;
#(
  parameter int COARSE_N  = 5,
  parameter int COARSE_W  = 3,
  parameter int FINE_W    = 4,
  parameter int KP_SHIFT  = 4,
  parameter int KI_SHIFT  = 0,
  parameter int FRAC_BITS = 4,
  parameter int ACC_W     = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic                data_smp,
  input  logic                edge_smp,
  output logic                early_pulse,
  output logic                late_pulse,
  output logic [COARSE_W-1:0] phase_coarse,
  output logic [FINE_W-1:0]   phase_fine
);

  pd_dir_t dir;
  int      move;
  logic    step_en;

  assign step_en = (dir != DIR_NONE);

  bbcdr_pd u_pd (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .data_smp  (data_smp),
    .edge_smp  (edge_smp),
    .dir       (dir),
    .early_q   (early_pulse),
    .late_q    (late_pulse)
  );

  bbcdr_loopfilt #(
    .KP_SHIFT  (KP_SHIFT),
    .KI_SHIFT  (KI_SHIFT),
    .FRAC_BITS (FRAC_BITS),
    .ACC_W     (ACC_W)
  ) u_filt (
    .clk  (clk),
    .rst  (rst),
    .dir  (dir),
    .move (move)
  );

  bbcdr_rotator #(
    .COARSE_N (COARSE_N),
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
  ) u_rot (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .move    (move),
    .coarse  (phase_coarse),
    .fine    (phase_fine)
  );

  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(phase_coarse) && $stable(phase_fine));

  assert_pulse_follows_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (early_pulse || late_pulse) |-> $past(smp_valid));

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
    early_pulse |=> !early_pulse || $past(smp_valid, 1));

endmodule

// File: tb/test_bbcdr_tracker.sv
module test_bbcdr_tracker;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic       data_smp = 1'b0;
  logic       edge_smp = 1'b0;
  logic       early_pulse;
  logic       late_pulse;
  logic [2:0] phase_coarse;
  logic [3:0] phase_fine;

  always #4 clk = ~clk;

  bbcdr_tracker i_bbcdr_tracker (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .data_smp     (data_smp),
    .edge_smp     (edge_smp),
    .early_pulse  (early_pulse),
    .late_pulse   (late_pulse),
    .phase_coarse (phase_coarse),
    .phase_fine   (phase_fine)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference: integers, 80-entry ring
  int m_prev = 0, m_have = 0, m_acc = 0, m_res = 0, m_pos = 0;
  int m_e = 0, m_l = 0;

  function automatic int floor_div16(input int t);
    int q;
    q = t / 16;
    if (t < 0 && (t % 16) != 0) q = q - 1;
    return q;
  endfunction

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      m_prev = 0; m_have = 0; m_acc = 0; m_res = 0; m_pos = 0; m_e = 0; m_l = 0;
    end else begin
      m_e = 0; m_l = 0;
      if (smp_valid) begin
        if (m_have != 0 && int'(data_smp) != m_prev) begin
          int s, tot, mv;
          if (int'(edge_smp) != m_prev) begin m_l = 1; s = -1; end
          else begin m_e = 1; s = 1; end
          m_acc = m_acc + s;
          if (m_acc > 511) m_acc = 511;
          if (m_acc < -512) m_acc = -512;
          tot = 16 * s + m_acc + m_res;
          mv = floor_div16(tot);
          m_res = tot - 16 * mv;
          m_pos = ((m_pos + mv) % 80 + 80) % 80;
        end
        m_prev = int'(data_smp);
        m_have = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(int'(early_pulse) == m_e, "R3 early pulse", int'(early_pulse), m_e);
      chk(int'(late_pulse) == m_l, "R2 late pulse", int'(late_pulse), m_l);
      chk(int'(phase_coarse) * 16 + int'(phase_fine) == m_pos, "R7 R10 phase code",
          int'(phase_coarse) * 16 + int'(phase_fine), m_pos);
      chk(phase_coarse <= 3'd4, "R9 coarse range", int'(phase_coarse), 4);
    end
  end

  function automatic int code_now();
    return int'(phase_coarse) * 16 + int'(phase_fine);
  endfunction

  task automatic beat(input bit v, input bit d, input bit e);
    @(negedge clk);
    #1;
    smp_valid = v; data_smp = d; edge_smp = e;
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    smp_valid = 1'b0;
  endtask

  task automatic step_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // early: edge equals previous data; late: edge equals new data
  bit cur = 1'b0;
  task automatic early_bit();
    beat(1'b1, ~cur, cur);
    cur = ~cur;
  endtask
  task automatic late_bit();
    beat(1'b1, ~cur, ~cur);
    cur = ~cur;
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(phase_coarse == 3'd0 && phase_fine == 4'd0, "R1 reset code", code_now(), 0);
    chk(!early_pulse && !late_pulse, "R1 reset pulses",
        int'(early_pulse) + int'(late_pulse), 0);
    #1 rst = 1'b0;

    // R5: first accepted bit makes no decision
    beat(1'b1, 1'b1, 1'b0); cur = 1'b1;
    idle();
    @(negedge clk);
    chk(!early_pulse && !late_pulse && code_now() == 0, "R5 first bit silent",
        code_now(), 0);

    // R7 R10: one early decision -> fine 1
    early_bit(); idle();
    @(negedge clk);
    chk(phase_coarse == 3'd0 && phase_fine == 4'd1, "R10 one early step", code_now(), 1);
    // one late back to 0, second late wraps to 4/15 (R9)
    late_bit(); idle();
    @(negedge clk);
    chk(code_now() == 0, "R7 late step back", code_now(), 0);
    late_bit(); idle();
    @(negedge clk);
    chk(phase_coarse == 3'd4 && phase_fine == 4'd15, "R9 wrap below zero", code_now(), 79);

    // R4: no transitions or no strobe change nothing
    p0 = code_now();
    for (int i = 0; i < 40; i++) begin
      step_rand();
      if (lfsr[0]) beat(1'b1, cur, lfsr[1]);
      else beat(1'b0, lfsr[2], lfsr[3]);
      @(posedge clk);
      #1;
      chk(!early_pulse && !late_pulse, "R4 no pulse without transition",
          int'(early_pulse) + int'(late_pulse), 0);
    end
    idle();
    @(negedge clk);
    chk(code_now() == p0, "R4 code held", code_now(), p0);

    // random traffic with gaps
    for (int i = 0; i < 3000; i++) begin
      step_rand();
      beat(lfsr[0] | lfsr[4], lfsr[1], lfsr[2] ^ lfsr[7]);
      if (lfsr[0] | lfsr[4]) cur = lfsr[1];
    end
    idle();

    // R8: saturate the integral with a long early run
    for (int i = 0; i < 600; i++) early_bit();
    idle();
    @(negedge clk);
    p0 = code_now();
    for (int i = 0; i < 16; i++) early_bit();
    idle();
    @(negedge clk);
    chk(((code_now() - p0) % 80 + 80) % 80 == 47, "R8 saturated advance",
        ((code_now() - p0) % 80 + 80) % 80, 47);

    // long late run: negative limit and wrap downward (R8, R9)
    for (int i = 0; i < 1400; i++) late_bit();
    for (int i = 0; i < 200; i++) begin
      step_rand();
      if (lfsr[0]) early_bit(); else late_bit();
    end
    idle();
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule